// File: doc/BRIEF.md
# Serial Converter Host-Port Model

This block models the digital side of a multi-channel sampling converter so that a host controller can be exercised against synthesizable logic. The host drives a conversion strobe, a serial clock and a serial data line, and reads a serial data line back. A low strobe selects the port. While it is selected, the host shifts in a 14-bit configuration word and shifts out the most recently completed 16-bit result. The result can be followed by the configuration word that produced it. All host pins are sampled by the block's own clock through a parameterized synchronizer. The host serial clock can therefore run at any speed below a few block-clock cycles per phase.

Configuration is double-buffered. A complete word received in a frame becomes pending. The next rising edge of the strobe copies it into the active register, and the conversion started by that edge runs with it. Each accepted result is stored with the active word, so readback always returns the word that belongs to the result in front of it, not the word most recently written.

Result data enters through a valid/ready stream. After each conversion start the block raises `smp_ready` and holds it until a word is accepted. The data source may stall for as long as it likes. While it stalls, a frame opened in the meantime returns the previous completed result, and `smp_ready` stays high across further conversion starts. A parameter can replace the stream with an internal counter that produces one value per conversion start.

Top module: `adcif_serial_if`

## Requirements
- R1: After reset the pending and active configuration both equal `DEF_CFG`, `sdo_out`, `smp_ready` and `sck_viol` are low, and `rise_count` is 0. The first conversion started without a prior complete write is tagged with `DEF_CFG`.
- R2: While `cnv_in` is high, `sck_in` and `din_in` leave `rise_count`, the pending configuration and `sdo_out` unchanged, and `sdo_out` is low. Each `sck_in` transition seen while `cnv_in` is high produces a one-cycle pulse on `sck_viol`.
- R3: A falling edge of `cnv_in` opens a frame. The first 14 rising `sck_in` edges of the frame shift `din_in` in MSB first, and the 14th edge makes the word pending. Rising edges after the 14th do not change the pending word.
- R4: A frame that ends with fewer than 14 rising `sck_in` edges leaves the pending configuration unchanged.
- R5: A rising edge of `cnv_in` copies the pending word into the active configuration. A result accepted after that edge carries the active word as its tag.
- R6: `smp_ready` goes high on the cycle after a detected `cnv_in` rise and stays high until `smp_valid && smp_ready`. At that handshake `smp_data` becomes the stored result. A frame opened before the handshake returns the previous result.
- R7: With `busy_mode` = 0, `sdo_out` shows result bit 15 once the frame opens. After falling `sck_in` edge k it shows bit 15−k, for k = 1..15.
- R8: With `busy_mode` = 1, `sdo_out` is low once the frame opens. After falling `sck_in` edge k it shows result bit 16−k, for k = 1..16.
- R9: If bit 0 of the result's tag is 1, the 14 falling edges after the result LSB present tag bits 13 down to 0. `sdo_out` is low after that, and it is low right after the result LSB when tag bit 0 is 0.
- R10: Until the first result has been accepted after reset, `sdo_out` stays low in every frame.
- R11: `rise_count` is cleared when a frame opens, counts rising `sck_in` edges in the frame, and saturates at 2^`CNT_W`−1.
- R12: A change on `cnv_in`, `sck_in` or `din_in` takes effect on the outputs `SYNC_STAGES`+1 block-clock cycles after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all host pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_in | input | 1 | Conversion strobe; low selects the port, rising edge starts a conversion |
| sck_in | input | 1 | Host serial clock |
| din_in | input | 1 | Host serial data into the configuration shifter |
| busy_mode | input | 1 | Selects the leading-idle-bit output format; change only while `cnv_in` is high |
| smp_valid | input | 1 | Result stream valid |
| smp_ready | output | 1 | Result stream ready, open from conversion start until a word is accepted |
| smp_data | input | DATA_W | Result stream data |
| sdo_out | output | 1 | Serial data to the host |
| rise_count | output | CNT_W | Rising serial-clock edges in the current frame, saturating |
| sck_viol | output | 1 | One-cycle pulse per serial-clock transition seen while deselected |

## Verification
The bench builds the block with two synchronizer stages, the stream-fed result source and readback keyed on tag bit 0. With these settings every host edge lands three block-clock cycles late, and the bench's half-period of four cycles leaves room to sample each output bit. The stream build lets the bench stall the data source across a frame, show the previous result, and then accept data mid-frame. The 6-bit counter width makes saturation reachable within a 70-edge frame.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  typedef struct packed {
    logic cnv_rise;
    logic cnv_fall;
    logic sck_rise;
    logic sck_fall;
    logic sel;
  } edge_ev_t;
endpackage

// File: rtl/adcif_sync.sv
module adcif_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_none
      assign q = d;
    end else if (STAGES == 1) begin : g_one
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= d;
      end
      assign q = st_q;
    end else begin : g_many
      logic [STAGES-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= {st_q[STAGES-2:0], d};
      end
      assign q = st_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/adcif_edges.sv
module adcif_edges
  import adcif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cnv_in,
  input  logic     sck_in,
  input  logic     din_in,
  output edge_ev_t ev,
  output logic     din_s,
  output logic     viol
);
  logic cnv_s, sck_s, cnv_d, sck_d;

  adcif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cnv (
    .clk(clk), .rst_n(rst_n), .d(cnv_in), .q(cnv_s));
  adcif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
    .clk(clk), .rst_n(rst_n), .d(sck_in), .q(sck_s));
  adcif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_din (
    .clk(clk), .rst_n(rst_n), .d(din_in), .q(din_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_d <= 1'b1;
      sck_d <= 1'b0;
      viol  <= 1'b0;
    end else begin
      cnv_d <= cnv_s;
      sck_d <= sck_s;
      viol  <= (sck_s ^ sck_d) & cnv_s;
    end
  end

  always_comb begin
    ev.cnv_rise = cnv_s & ~cnv_d;
    ev.cnv_fall = ~cnv_s & cnv_d;
    ev.sck_rise = sck_s & ~sck_d;
    ev.sck_fall = ~sck_s & sck_d;
    ev.sel      = ~cnv_s;
  end

  // R2: a violation pulse only follows a deselected sample
  p_viol_when_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(cnv_s));
endmodule

// File: rtl/adcif_cfg_rx.sv
module adcif_cfg_rx #(
  parameter int               CFG_W   = 14,
  parameter int               CNT_W   = 6,
  parameter logic [CFG_W-1:0] DEF_CFG = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_rise,
  input  logic             cnv_fall,
  input  logic             sck_rise,
  input  logic             sel,
  input  logic             din_s,
  output logic [CFG_W-1:0] pending,
  output logic [CFG_W-1:0] active,
  output logic [CNT_W-1:0] rise_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CFG_W - 1);

  logic [CFG_W-1:0] shreg_q;
  logic [CFG_W-1:0] shifted;
  logic             take;

  assign take    = sck_rise & sel & ~cnv_fall;
  assign shifted = {shreg_q[CFG_W-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      pending  <= DEF_CFG;
      active   <= DEF_CFG;
      rise_cnt <= '0;
    end else begin
      if (cnv_fall) begin
        rise_cnt <= '0;
        shreg_q  <= '0;
      end else if (take) begin
        if (rise_cnt != CNT_MAX) rise_cnt <= rise_cnt + 1'b1;
        if (rise_cnt < WORD_LEN) shreg_q <= shifted;
        if (rise_cnt == LAST_BIT) pending <= shifted;
      end
      if (cnv_rise) active <= pending;
    end
  end

  p_pending_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(pending));
  p_active_changes_on_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_rise |=> $stable(active));
  p_count_saturates_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_cnt == CNT_MAX && !cnv_fall) |=> (rise_cnt == CNT_MAX));
endmodule

// File: rtl/adcif_conv.sv
module adcif_conv #(
  parameter int DATA_W      = 16,
  parameter int CFG_W       = 14,
  parameter bit USE_COUNTER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_rise,
  input  logic [CFG_W-1:0]  active,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] res,
  output logic [CFG_W-1:0]  res_tag,
  output logic              have_res
);
  generate
    if (USE_COUNTER) begin : g_cnt
      logic [DATA_W-1:0] ctr_q;
      logic              start_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ctr_q    <= '0;
          start_q  <= 1'b0;
          res      <= '0;
          res_tag  <= '0;
          have_res <= 1'b0;
        end else begin
          start_q <= cnv_rise;
          if (start_q) begin
            res      <= ctr_q;
            res_tag  <= active;
            have_res <= 1'b1;
            ctr_q    <= ctr_q + 1'b1;
          end
        end
      end
      assign smp_ready = 1'b0;
    end else begin : g_port
      logic rdy_q;
      logic hs;
      assign hs = smp_valid & rdy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rdy_q    <= 1'b0;
          res      <= '0;
          res_tag  <= '0;
          have_res <= 1'b0;
        end else begin
          if (cnv_rise)  rdy_q <= 1'b1;
          else if (hs)   rdy_q <= 1'b0;
          if (hs) begin
            res      <= smp_data;
            res_tag  <= active;
            have_res <= 1'b1;
          end
        end
      end
      assign smp_ready = rdy_q;

      p_ready_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_rise |=> smp_ready);
      p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && smp_ready) |=> $stable(res));
    end
  endgenerate
endmodule

// File: rtl/adcif_tx.sv
module adcif_tx #(
  parameter int DATA_W = 16,
  parameter int CFG_W  = 14,
  parameter int RB_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_rise,
  input  logic              cnv_fall,
  input  logic              sck_fall,
  input  logic              sel,
  input  logic              busy_mode,
  input  logic [DATA_W-1:0] res,
  input  logic [CFG_W-1:0]  res_tag,
  input  logic              have_res,
  output logic              sdo
);
  localparam int TX_W = DATA_W + CFG_W + 1;

  logic [TX_W-1:0]  sr_q;
  logic [TX_W-1:0]  load_w;
  logic [CFG_W-1:0] rb_word;

  assign rb_word = res_tag[RB_BIT] ? res_tag : '0;

  always_comb begin
    if (!have_res)      load_w = '0;
    else if (busy_mode) load_w = {1'b0, res, rb_word};
    else                load_w = {res, rb_word, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sr_q <= '0;
    else if (cnv_fall)         sr_q <= load_w;
    else if (cnv_rise)         sr_q <= '0;
    else if (sck_fall && sel)  sr_q <= {sr_q[TX_W-2:0], 1'b0};
  end

  assign sdo = sr_q[TX_W-1];

  p_quiet_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise |=> !sdo);
  p_busy_leads_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_fall && busy_mode) |=> !sdo);
  p_no_result_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !have_res |-> !sdo);
endmodule

// File: rtl/adcif_serial_if.sv
module adcif_serial_if
  import adcif_pkg::*;
#(
  parameter int               DATA_W      = 16,
  parameter int               CFG_W       = 14,
  parameter int               CNT_W       = 6,
  parameter int               SYNC_STAGES = 2,
  parameter bit               USE_COUNTER = 1'b0,
  parameter int               RB_BIT      = 0,
  parameter logic [CFG_W-1:0] DEF_CFG     = 14'h2A71
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_in,
  input  logic              sck_in,
  input  logic              din_in,
  input  logic              busy_mode,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  output logic              sdo_out,
  output logic [CNT_W-1:0]  rise_count,
  output logic              sck_viol
);
  edge_ev_t          ev;
  logic              din_s;
  logic [CFG_W-1:0]  cfg_pending, cfg_active, res_tag;
  logic [DATA_W-1:0] res;
  logic              have_res;

  adcif_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_n), .cnv_in(cnv_in), .sck_in(sck_in), .din_in(din_in),
    .ev(ev), .din_s(din_s), .viol(sck_viol));

  adcif_cfg_rx #(.CFG_W(CFG_W), .CNT_W(CNT_W), .DEF_CFG(DEF_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cnv_rise(ev.cnv_rise), .cnv_fall(ev.cnv_fall),
    .sck_rise(ev.sck_rise), .sel(ev.sel), .din_s(din_s),
    .pending(cfg_pending), .active(cfg_active), .rise_cnt(rise_count));

  adcif_conv #(.DATA_W(DATA_W), .CFG_W(CFG_W), .USE_COUNTER(USE_COUNTER)) u_conv (
    .clk(clk), .rst_n(rst_n), .cnv_rise(ev.cnv_rise), .active(cfg_active),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data),
    .res(res), .res_tag(res_tag), .have_res(have_res));

  adcif_tx #(.DATA_W(DATA_W), .CFG_W(CFG_W), .RB_BIT(RB_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .cnv_rise(ev.cnv_rise), .cnv_fall(ev.cnv_fall),
    .sck_fall(ev.sck_fall), .sel(ev.sel), .busy_mode(busy_mode),
    .res(res), .res_tag(res_tag), .have_res(have_res), .sdo(sdo_out));

  // R1: the pending word is the reset default until a complete write
  p_pending_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pending != DEF_CFG) |-> $past(cfg_pending != DEF_CFG || ev.sck_rise));
endmodule

// File: tb/adcif_serial_if_test.sv
module adcif_serial_if_test;
  localparam int SYNC = 2;
  localparam int D    = SYNC + 1;
  localparam int HALF = 4;
  localparam logic [13:0] DEF = 14'h2A71;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b1, sck = 1'b0, din = 1'b0, busy = 1'b0, vld = 1'b0;
  logic [15:0] dat = '0;
  logic ready, sdo, viol;
  logic [5:0] rcount;

  int tests = 0;
  int fails = 0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  adcif_serial_if #(.SYNC_STAGES(SYNC), .USE_COUNTER(1'b0), .RB_BIT(0), .DEF_CFG(DEF)) uut (
    .clk(clk), .rst_n(rst_n), .cnv_in(cnv), .sck_in(sck), .din_in(din),
    .busy_mode(busy), .smp_valid(vld), .smp_ready(ready), .smp_data(dat),
    .sdo_out(sdo), .rise_count(rcount), .sck_viol(viol));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic bm, input logic [15:0] d, input logic [13:0] t, input int k);
    int idx;
    idx = bm ? k - 1 : k;
    if (idx < 0) return 1'b0;
    if (idx < 16) return d[15 - idx];
    if (idx < 30 && t[0]) return t[29 - idx];
    return 1'b0;
  endfunction

  // ---------------- behavioural reference, compared every clock ----------------
  logic hc [0:D];
  logic hk [0:D];
  logic hd [0:D];
  logic v_q;
  logic [15:0] d_q;
  initial begin
    for (int i = 0; i <= D; i++) begin hc[i] = 1'b1; hk[i] = 1'b0; hd[i] = 1'b0; end
    v_q = 1'b0; d_q = '0;
  end
  always @(posedge clk) begin
    for (int i = D; i > 0; i--) begin hc[i] = hc[i-1]; hk[i] = hk[i-1]; hd[i] = hd[i-1]; end
    hc[0] = cnv; hk[0] = sck; hd[0] = din;
    v_q = vld; d_q = dat;
  end

  logic [13:0] m_pend, m_act, m_sh, m_rtag, m_ftag;
  logic [15:0] m_res, m_fres;
  logic m_have, m_ready, m_fok, m_fbusy, m_viol;
  int m_rcnt, m_fcnt;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pend = DEF; m_act = DEF; m_sh = '0; m_rtag = '0; m_ftag = '0;
      m_res = '0; m_fres = '0; m_have = 0; m_ready = 0; m_fok = 0; m_fbusy = 0;
      m_viol = 0; m_rcnt = 0; m_fcnt = 0;
    end else begin
      logic cn, co, sn, so, dn, hsk;
      logic [13:0] old_act;
      cn = hc[D-1]; co = hc[D]; sn = hk[D-1]; so = hk[D]; dn = hd[D-1];
      hsk = v_q && m_ready;
      old_act = m_act;
      m_viol = (sn != so) && cn;
      if (!cn && co) begin
        m_fres = m_res; m_ftag = m_rtag; m_fok = m_have; m_fbusy = busy;
        m_fcnt = 0; m_rcnt = 0; m_sh = '0;
      end else if (!cn) begin
        if (sn && !so) begin
          if (m_rcnt < 14) begin
            m_sh = {m_sh[12:0], dn};
            if (m_rcnt == 13) m_pend = m_sh;
          end
          if (m_rcnt < 63) m_rcnt++;
        end
        if (!sn && so) m_fcnt++;
      end
      if (cn && !co) begin
        m_act = m_pend; m_fok = 0; m_ready = 1;
      end else if (hsk) m_ready = 0;
      if (hsk) begin m_res = d_q; m_rtag = old_act; m_have = 1; end
      if (model_on) begin
        check("R12 sdo model", sdo, m_fok ? exp_bit(m_fbusy, m_fres, m_ftag, m_fcnt) : 1'b0);
        check("R12 ready model", ready, m_ready);
        check("R12 count model", rcount, m_rcnt);
        check("R12 viol model", viol, m_viol);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [0:71] got;

  task automatic run_frame(input logic [13:0] wcfg, input int nedge);
    cnv = 1'b0;
    wait_cyc(HALF);
    got = '0;
    got[0] = sdo;
    for (int e = 1; e <= nedge; e++) begin
      din = (e <= 14) ? wcfg[14 - e] : 1'b1;
      wait_cyc(1);
      sck = 1'b1;
      wait_cyc(HALF);
      sck = 1'b0;
      wait_cyc(HALF);
      if (e <= 71) got[e] = sdo;
    end
  endtask

  task automatic start_conv(input logic give, input logic [15:0] d);
    vld = give; dat = d;
    cnv = 1'b1;
    wait_cyc(10);
    vld = 1'b0;
  endtask

  task automatic chk_frame(input logic bm, input logic [15:0] d, input logic [13:0] t, input logic have);
    for (int k = 0; k < 32; k++) begin
      int idx;
      idx = bm ? k - 1 : k;
      if (!have)          check("R10 no result yet", got[k], 1'b0);
      else if (idx < 16)  check(bm ? "R8 busy result bit" : "R7 result bit", got[k], exp_bit(bm, d, t, k));
      else                check("R9 readback bit", got[k], exp_bit(bm, d, t, k));
    end
  endtask

  function automatic logic [13:0] rb_word(input int first);
    logic [13:0] w;
    for (int i = 0; i < 14; i++) w[13 - i] = got[first + i];
    return w;
  endfunction

  localparam logic [13:0] CA = 14'h0F5A;
  localparam logic [13:0] CB = 14'h3693;
  localparam logic [13:0] CC = 14'h1D27;
  localparam logic [15:0] D1 = 16'hB3C5, D2 = 16'h6E18, D3 = 16'h0F0F, D4 = 16'hD2A7;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int pulses;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(1);
    model_on = 1'b1;
    check("R1 sdo", sdo, 1'b0);
    check("R1 ready", ready, 1'b0);
    check("R1 count", rcount, 0);
    check("R1 viol", viol, 1'b0);

    // frame 0: short write, no result yet
    run_frame(14'h0000, 5);
    check("R10 frame 0", got[0:5], 6'b0);
    check("R11 count 5", rcount, 5);
    start_conv(1'b1, D1);
    check("R6 ready after accept", ready, 1'b0);

    // frame 1: plain format, default tag readback, write CA with extra edges
    busy = 1'b0;
    run_frame(CA, 32);
    chk_frame(1'b0, D1, DEF, 1'b1);
    check("R1 default tag", rb_word(16), DEF);
    check("R4 partial write ignored", rb_word(16), DEF);
    check("R11 count 32", rcount, 32);
    start_conv(1'b1, D2);

    // frame 2: leading idle bit, CA has readback off; write CB
    busy = 1'b1;
    wait_cyc(2);
    run_frame(CB, 32);
    chk_frame(1'b1, D2, CA, 1'b1);
    check("R9 readback off", got[17:31], 15'b0);

    // conversion 3 stalls: latency and ready
    busy = 1'b0;
    vld = 1'b0;
    cnv = 1'b1;
    wait_cyc(2);
    check("R12 ready not yet", ready, 1'b0);
    wait_cyc(1);
    check("R12 ready after latency", ready, 1'b1);
    wait_cyc(6);

    // frame 3 opened before the handshake: previous result shown
    run_frame(CC, 32);
    chk_frame(1'b0, D2, CA, 1'b1);
    check("R6 stalled ready held", ready, 1'b1);
    vld = 1'b1; dat = D3;
    wait_cyc(1);
    vld = 1'b0;
    wait_cyc(1);
    check("R6 ready drops", ready, 1'b0);
    start_conv(1'b1, D4);

    // serial clock while deselected
    pulses = 0;
    for (int i = 0; i < 4; i++) begin
      if (i == 0) sck = 1'b1;
      if (i == 2) sck = 1'b0;
      din = ~din;
      for (int j = 0; j < HALF; j++) begin
        wait_cyc(1);
        if (viol) pulses++;
        check("R2 sdo low deselected", sdo, 1'b0);
      end
    end
    wait_cyc(4);
    if (viol) pulses++;
    check("R2 violation pulses", pulses, 2);
    check("R2 count unchanged", rcount, 32);

    // frame 4: CC readback with D4, and counter saturation
    run_frame(CB, 70);
    chk_frame(1'b0, D4, CC, 1'b1);
    check("R3 written word", rb_word(16), CC);
    check("R5 tag of conversion", rb_word(16), CC);
    check("R11 saturation", rcount, 63);
    start_conv(1'b1, D1);
    wait_cyc(4);

    model_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule